// File: doc/BRIEF.md
# Pad-to-Channel Interrupt Router

The router takes a wide bundle of asynchronous pad interrupt lines and steers one of them onto each of eight output channels. Every channel has an 8-bit pad index held in a small register file, so a channel can name any line in a 256-entry index space. The pads that are actually wired in are set by a parameter. The selected lines pass through a two-flop synchronizer, a per-channel multiplexer and an output flop. They then go on to a separate trigger-conditioning stage.

The block has four 32-bit registers on a plain word-indexed bus with byte-enabled writes and registered reads. The first register carries a master enable in its top bit. Its remaining 31 bits are passed unchanged to the conditioning stage as trigger configuration. Two registers each hold four pad-select bytes. The last register holds a 4-bit filter code per channel, which also goes to the conditioning stage. The router has no streaming data path, so every pin is a plain level or strobe with no back-pressure.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four registers read zero, so every channel selects pad 0 and the master enable is off. All `chan_irq` bits are 0.
- R2: The register index `bus_word` maps as follows: 0 is control, 1 is selects for channels 0-3, 2 is selects for channels 4-7, and 3 is the filter register. These correspond to byte offsets 0x0, 0x4, 0x8 and 0xC.
- R3: On a write, byte k of the addressed register (bits 8k+7..8k) takes `bus_wdata` only if `bus_be[k]` is 1. A write with `bus_be` = 0 changes nothing.
- R4: A read strobe returns the value the register held before that edge on `rd_data` after the same edge. `rd_data` holds its value when no read is strobed.
- R5: Channel n takes its pad index from bits (n mod 4)*8+7..(n mod 4)*8. For n<4 these bits are in register 1; for n>=4 they are in register 2.
- R6: If the master enable is on, `chan_irq[n]` equals the selected pad line. A change on `pad_in` shows at the output three clock edges later: two synchronizer flops, then the output flop.
- R7: Bit 31 of the control register is the master enable. While it is 0, `chan_irq` is 0 from the next edge on.
- R8: A pad index at or above `NUM_PADS` drives a constant 0 into its channel.
- R9: `filt_sel` equals register 3, with channel n's code at bits 4n+3..4n. `trig_cfg` equals control bits 30..0. Both follow a write from the edge that performs it.
- R10: A new pad index shows on `chan_irq` one edge after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_PADS | Asynchronous pad interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| rd_data | output | 32 | Registered read data |
| chan_irq | output | 8 | Routed, enabled channel interrupt lines |
| trig_cfg | output | 31 | Control bits 30..0 for the conditioning stage |
| filt_sel | output | 32 | Per-channel 4-bit filter codes |

## Verification
A pad edge is due on `chan_irq` on the third clock edge after it is driven. A select or enable write is due on the first edge after the one that stores it. Read data and the `trig_cfg`/`filt_sel` fields are due on the same edge as the strobe or write. The bench has a behavioural model that applies those delays to a copy of the pad history and the register values. The model updates on each rising edge, and the bench compares it with every output on the falling edge, away from the edge where the design changes. Directed checks then count falling edges explicitly: for a pad edge they expect 0, 0 and then 1; for a select change they expect old then new.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int NUM_CH   = 8;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 4;
  localparam int REG_W    = 32;
  localparam int NUM_REGS = 4;
  localparam int PAD_SPAN = 1 << SEL_W;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_SELLO = 2'd1,
    RG_SELHI = 2'd2,
    RG_FILT  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/prt_regs.sv
module prt_regs
  import prt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_word,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [REG_W/8-1:0] bus_be,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] sel_lo_q,
  output logic [REG_W-1:0] sel_hi_q,
  output logic [REG_W-1:0] filt_q
);
  localparam int NBYTES = REG_W / 8;

  logic [REG_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NBYTES; b++)
        if (bus_be[b]) regs_q[bus_word][b*8 +: 8] <= bus_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (bus_rd) rd_data <= regs_q[bus_word];
  end

  assign ctrl_q   = regs_q[RG_CTRL];
  assign sel_lo_q = regs_q[RG_SELLO];
  assign sel_hi_q = regs_q[RG_SELHI];
  assign filt_q   = regs_q[RG_FILT];

  // R3
  be_zero_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be == '0) |=> ($stable(ctrl_q) && $stable(sel_lo_q) &&
                                  $stable(sel_hi_q) && $stable(filt_q)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data));
endmodule

// File: rtl/prt_sync.sv
module prt_sync #(
  parameter int WIDTH = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/prt_chan.sv
module prt_chan
  import prt_pkg::*;
#(
  parameter int NUM_PADS = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAD_SPAN-1:0] pads,
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  output logic                irq_q
);
  logic hit;
  assign hit = pads[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= en & hit;
  end

  generate
    if (NUM_PADS < PAD_SPAN) begin : g_range_chk
      // R8
      oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel) >= NUM_PADS) |=> !irq_q);
    end
  endgenerate
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import prt_pkg::*;
#(
  parameter int NUM_PADS = 160
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PADS-1:0]  pad_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_word,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_be,
  output logic [31:0]          rd_data,
  output logic [7:0]           chan_irq,
  output logic [30:0]          trig_cfg,
  output logic [31:0]          filt_sel
);
  localparam int EN_BIT = REG_W - 1;

  logic [REG_W-1:0]          ctrl_q, sel_lo_q, sel_hi_q, filt_q;
  logic [NUM_PADS-1:0]       pads_sync;
  logic [PAD_SPAN-1:0]       pads_ext;
  logic [NUM_CH*SEL_W-1:0]   sel_all;

  prt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .rd_data(rd_data), .ctrl_q(ctrl_q), .sel_lo_q(sel_lo_q),
    .sel_hi_q(sel_hi_q), .filt_q(filt_q)
  );

  prt_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(pads_sync)
  );

  generate
    if (NUM_PADS < PAD_SPAN) begin : g_pad_ext
      assign pads_ext = {{(PAD_SPAN-NUM_PADS){1'b0}}, pads_sync};
    end else begin : g_pad_full
      assign pads_ext = pads_sync[PAD_SPAN-1:0];
    end
  endgenerate

  assign sel_all = {sel_hi_q, sel_lo_q};

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      prt_chan #(.NUM_PADS(NUM_PADS)) u_chan (
        .clk(clk), .rst_n(rst_n), .pads(pads_ext),
        .sel(sel_all[n*SEL_W +: SEL_W]), .en(ctrl_q[EN_BIT]),
        .irq_q(chan_irq[n])
      );
    end
  endgenerate

  assign trig_cfg = ctrl_q[EN_BIT-1:0];
  assign filt_sel = filt_q;

  // R7
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[EN_BIT] |=> (chan_irq == '0));

  // R9
  cfg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == RG_FILT && bus_be == 4'hF) |=> (filt_sel == $past(bus_wdata)));
endmodule

// File: tb/pad_irq_router_tb.sv
module pad_irq_router_tb;
  localparam int NP = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_word = '0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   rd_data;
  logic [7:0]    chan_irq;
  logic [30:0]   trig_cfg;
  logic [31:0]   filt_sel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pad_irq_router #(.NUM_PADS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .rd_data(rd_data), .chan_irq(chan_irq), .trig_cfg(trig_cfg), .filt_sel(filt_sel)
  );

  // behavioural reference
  logic [31:0]   mreg [4];
  logic [NP-1:0] m_s1, m_s2;
  logic [7:0]    exp_irq;
  logic [31:0]   exp_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 4; r++) mreg[r] = '0;
      m_s1 = '0; m_s2 = '0; exp_irq = '0; exp_rd = '0;
    end else begin
      for (int n = 0; n < 8; n++) begin
        int s;
        s = (n < 4) ? int'(mreg[1][(n%4)*8 +: 8]) : int'(mreg[2][(n%4)*8 +: 8]);
        exp_irq[n] = 1'b0;
        if (mreg[0][31] && s < NP) exp_irq[n] = m_s2[s];
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_rd) exp_rd = mreg[bus_word];
      if (bus_wr)
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) mreg[bus_word][b*8 +: 8] = bus_wdata[b*8 +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 chan_irq vs model", 32'(chan_irq), 32'(exp_irq));
      chk("R4 rd_data vs model", rd_data, exp_rd);
      chk("R9 filt_sel vs model", filt_sel, mreg[3]);
      chk("R9 trig_cfg vs model", 32'(trig_cfg), 32'(mreg[0][30:0]));
    end
  end

  task automatic wr(input logic [1:0] w, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_word = w; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    bus_rd = 1'b1; bus_word = w;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 chan_irq at reset", 32'(chan_irq), 32'h0);
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      chk("R1 register reset value", v, 32'h0);
    end
    // R2 / R5: register layout and read-back
    wr(2'd1, 32'h0302_0100, 4'hF);
    wr(2'd2, 32'h0B0A_0907, 4'hF);
    wr(2'd0, 32'h8000_0000, 4'b1000);
    rd(2'd1, v); chk("R2 select low read-back", v, 32'h0302_0100);
    rd(2'd2, v); chk("R5 select high read-back", v, 32'h0B0A_0907);
    rd(2'd0, v); chk("R2 control read-back", v, 32'h8000_0000);
    // R3: byte enables
    wr(2'd1, 32'hAABB_CCDD, 4'b0010);
    rd(2'd1, v); chk("R3 partial byte write", v, 32'h0302_CC00);
    wr(2'd1, 32'hFFFF_FFFF, 4'b0000);
    rd(2'd1, v); chk("R3 empty byte mask", v, 32'h0302_CC00);
    // R8: channel 1 now selects 204, above NUM_PADS
    pad_in = '1;
    repeat (4) @(negedge clk);
    chk("R8 out-of-range select", 32'(chan_irq[1]), 32'h0);
    chk("R6 channel 0 follows pad 0", 32'(chan_irq[0]), 32'h1);
    // R7: master enable off
    wr(2'd0, 32'h0000_00A5, 4'hF);
    @(negedge clk);
    chk("R7 master disabled", 32'(chan_irq), 32'h0);
    chk("R9 trig_cfg", 32'(trig_cfg), 32'h0000_00A5);
    wr(2'd3, 32'h7654_3210, 4'hF);
    chk("R9 filter codes", filt_sel, 32'h7654_3210);
    chk("R9 channel 5 code", 32'(filt_sel[23:20]), 32'h5);
    // R6: latency of a pad edge (channel 4 selects pad 7)
    wr(2'd0, 32'h8000_0000, 4'hF);
    pad_in = '0;
    repeat (4) @(negedge clk);
    pad_in[7] = 1'b1;
    @(negedge clk); chk("R6 latency edge 1", 32'(chan_irq[4]), 32'h0);
    @(negedge clk); chk("R6 latency edge 2", 32'(chan_irq[4]), 32'h0);
    @(negedge clk); chk("R6 latency edge 3", 32'(chan_irq[4]), 32'h1);
    // R10: select change shows one edge later (pad 8 is low)
    bus_wr = 1'b1; bus_word = 2'd2; bus_wdata = 32'h0000_0008; bus_be = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    chk("R10 old select still visible", 32'(chan_irq[4]), 32'h1);
    @(negedge clk);
    chk("R10 new select visible", 32'(chan_irq[4]), 32'h0);
    // mixed traffic checked against the model on every cycle
    for (int i = 0; i < 2000; i++) begin
      for (int k = 0; k < NP; k += 32) pad_in[k +: 32] = $urandom;
      if ((i % 7) == 0)
        wr(2'($urandom_range(3, 0)), $urandom | 32'h8000_0000, 4'($urandom));
      else if ((i % 5) == 0) begin
        rd(2'($urandom_range(3, 0)), v);
      end else
        @(negedge clk);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule